// File: doc/BRIEF.md
# ECC Error Capture Register

This block is the error log of a memory controller. A downstream ECC checker reports each read with a one-cycle pulse: one line for a corrected single-bit error and one for an uncorrectable multi-bit error. Each pulse comes with the failing physical address and the 8-bit syndrome. The block records only the first error. It keeps the upper address bits, the syndrome and a sticky flag that names the error type. From that point the record is frozen, so later errors cannot overwrite the original evidence.

Software reaches the log through a single 32-bit register with a write strobe and a read value. The same register holds three control bits. One bit disables the write-back scrub request for corrected reads. One bit routes logged single-bit errors to a non-maskable interrupt line. One bit routes logged multi-bit errors to a bus-error line. Software releases the log by writing ones to both flag bits in the same write.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, every register bit reads 0, and `scrub_req`, `nmi_out` and `berr_out` are all 0.
- R2: When both flags are clear, a `sbe_pulse` without `mbe_pulse` sets bit 0 (single-bit flag). From the next cycle, bits 30:12 read `err_addr[31:13]` and bits 11:4 read `err_syn`.
- R3: When both flags are clear, a `mbe_pulse` sets bit 1 (multi-bit flag) and captures the address and syndrome in the same way as R2.
- R4: When `sbe_pulse` and `mbe_pulse` arrive in the same cycle with both flags clear, only bit 1 is set, and bit 0 stays 0.
- R5: While either flag is set, further error pulses are ignored. Bits 30:12, bits 11:4 and both flags keep their values. This also holds for a pulse in the same cycle as a clearing write, which then leaves both flags at 0.
- R6: A write clears the flags only when `reg_wdata[1:0]` is 2'b11, and then both flags clear. Writing 2'b01, 2'b10 or 2'b00 to bits 1:0 leaves both flags unchanged. A clear leaves bits 30:12 and 11:4 holding the old capture.
- R7: After a clear, the next error is captured, and its address and syndrome replace the old ones.
- R8: Bits 31, 3 and 2 are read/write and take the value of the corresponding `reg_wdata` bits on every write. Bit 31 disables scrubbing, bit 3 enables bus-error signalling and bit 2 enables NMI signalling.
- R9: `nmi_out` is 1 exactly while bit 0 and bit 2 are both 1.
- R10: `berr_out` is 1 exactly while bit 1 and bit 3 are both 1.
- R11: `scrub_req` is a one-cycle pulse in the cycle after a `sbe_pulse` that has no `mbe_pulse` beside it, issued only when bit 31 is 0. It does not depend on the flags.
- R12: Writes never change bits 30:4. Those bits change only through error capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sbe_pulse | input | 1 | Corrected single-bit error seen on a read |
| mbe_pulse | input | 1 | Uncorrectable multi-bit error seen on a read |
| err_addr | input | 32 | Physical address of the failing read |
| err_syn | input | 8 | Syndrome of the failing read |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read value |
| scrub_req | output | 1 | Write-back scrub request for a corrected read |
| nmi_out | output | 1 | Non-maskable interrupt for a logged single-bit error |
| berr_out | output | 1 | Bus-error signal for a logged multi-bit error |

## Verification
The properties assume that the error pulses, address and syndrome are sampled only at a clock edge, and that address and syndrome are valid whenever a pulse is high. The properties assume nothing about how long a pulse lasts or how pulses are spaced: a pulse held high while a flag is set must simply be ignored. The stimulus drives every input on the falling edge and keeps each pulse and each write to exactly one cycle. It changes the address and syndrome between captures, so that a frozen field can be told apart from a newly written one.

// File: rtl/ecc_log_pkg.sv
// Package: ecc_log_pkg
// Shared bit positions and the control-bit bundle for the ECC error log.
// Assumes the register is laid out with the flags and enables in the low
// nibble, the syndrome above them, the address bits above the syndrome and
// the scrub-disable bit on top.
package ecc_log_pkg;
    localparam int BIT_SBE     = 0;
    localparam int BIT_MBE     = 1;
    localparam int BIT_NMI_EN  = 2;
    localparam int BIT_BERR_EN = 3;
    localparam int SYN_LSB     = 4;

    typedef struct packed {
        logic scrub_dis;
        logic berr_en;
        logic nmi_en;
    } log_ctrl_t;
endpackage

// File: rtl/ecc_log_ctrl.sv
// Module: ecc_log_ctrl
// Holds the three software control bits and decodes the write that clears
// both flags together. Assumes reg_wr is a one-cycle strobe per write.
module ecc_log_ctrl
    import ecc_log_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output log_ctrl_t        ctrl,
    output logic             clr_both
);
    localparam int DIS_BIT = REG_W - 1;

    log_ctrl_t ctrl_q;

    // Purpose: update the control bits on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr) begin
            ctrl_q.scrub_dis <= wdata[DIS_BIT];
            ctrl_q.berr_en   <= wdata[BIT_BERR_EN];
            ctrl_q.nmi_en    <= wdata[BIT_NMI_EN];
        end
    end

    // Purpose: a clear is honoured only when both flag bits are written 1.
    always_comb begin
        clr_both = wr & wdata[BIT_SBE] & wdata[BIT_MBE];
    end

    assign ctrl = ctrl_q;

    logic unused_wdata_mid;
    assign unused_wdata_mid = ^wdata[DIS_BIT-1:SYN_LSB];
endmodule

// File: rtl/ecc_log_capture.sv
// Module: ecc_log_capture
// Records the first ECC event: the type flag, the kept address bits and the
// syndrome. While a flag is set, the record is frozen and pulses are ignored.
// A multi-bit pulse wins over a single-bit pulse in the same cycle.
module ecc_log_capture #(
    parameter int KEEP_W = 19,
    parameter int SYN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sbe_in,
    input  logic              mbe_in,
    input  logic [KEEP_W-1:0] addr_hi,
    input  logic [SYN_W-1:0]  syn_in,
    input  logic              clr_both,
    output logic              sbe_flag,
    output logic              mbe_flag,
    output logic [KEEP_W-1:0] addr_q,
    output logic [SYN_W-1:0]  syn_q
);
    logic idle;
    logic take;

    // Purpose: the log is open only while neither flag is set.
    always_comb begin
        idle = ~sbe_flag & ~mbe_flag;
        take = idle & (sbe_in | mbe_in);
    end

    // Purpose: set the flag for the first error; clear both on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sbe_flag <= 1'b0;
            mbe_flag <= 1'b0;
        end else if (take) begin
            mbe_flag <= mbe_in;
            sbe_flag <= ~mbe_in;
        end else if (clr_both) begin
            sbe_flag <= 1'b0;
            mbe_flag <= 1'b0;
        end
    end

    // Purpose: latch the address and syndrome only when an error is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            syn_q  <= '0;
        end else if (take) begin
            addr_q <= addr_hi;
            syn_q  <= syn_in;
        end
    end
endmodule

// File: rtl/ecc_log_signal.sv
// Module: ecc_log_signal
// Drives the scrub request, NMI and bus-error lines. The scrub request is a
// registered one-cycle pulse per corrected read. The NMI and bus-error lines
// are levels that follow the flags gated by their enables.
module ecc_log_signal
    import ecc_log_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sbe_in,
    input  logic      mbe_in,
    input  log_ctrl_t ctrl,
    input  logic      sbe_flag,
    input  logic      mbe_flag,
    output logic      scrub_req,
    output logic      nmi_out,
    output logic      berr_out
);
    // Purpose: request a write-back for a corrected read unless disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scrub_req <= 1'b0;
        end else begin
            scrub_req <= sbe_in & ~mbe_in & ~ctrl.scrub_dis;
        end
    end

    // Purpose: gate the logged flags onto the interrupt lines.
    always_comb begin
        nmi_out  = sbe_flag & ctrl.nmi_en;
        berr_out = mbe_flag & ctrl.berr_en;
    end
endmodule

// File: rtl/ecc_err_log.sv
// Module: ecc_err_log
// Top of the ECC error capture register. Connects the control bits, the
// capture record and the signalling outputs, and assembles the read value.
// Assumes the error pulses, address and syndrome are synchronous to clk.
module ecc_err_log
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int KEEP_W = 19,
    parameter int SYN_W  = 8,
    localparam int REG_W = KEEP_W + SYN_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sbe_pulse,
    input  logic              mbe_pulse,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic [SYN_W-1:0]  err_syn,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              scrub_req,
    output logic              nmi_out,
    output logic              berr_out
);
    localparam int DROP_W = ADDR_W - KEEP_W;

    log_ctrl_t         ctrl;
    logic              clr_both;
    logic              sbe_flag;
    logic              mbe_flag;
    logic [KEEP_W-1:0] addr_q;
    logic [SYN_W-1:0]  syn_q;

    ecc_log_ctrl #(.REG_W(REG_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .ctrl     (ctrl),
        .clr_both (clr_both)
    );

    ecc_log_capture #(.KEEP_W(KEEP_W), .SYN_W(SYN_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .sbe_in   (sbe_pulse),
        .mbe_in   (mbe_pulse),
        .addr_hi  (err_addr[ADDR_W-1 -: KEEP_W]),
        .syn_in   (err_syn),
        .clr_both (clr_both),
        .sbe_flag (sbe_flag),
        .mbe_flag (mbe_flag),
        .addr_q   (addr_q),
        .syn_q    (syn_q)
    );

    ecc_log_signal u_signal (
        .clk       (clk),
        .rst_n     (rst_n),
        .sbe_in    (sbe_pulse),
        .mbe_in    (mbe_pulse),
        .ctrl      (ctrl),
        .sbe_flag  (sbe_flag),
        .mbe_flag  (mbe_flag),
        .scrub_req (scrub_req),
        .nmi_out   (nmi_out),
        .berr_out  (berr_out)
    );

    // Purpose: assemble the software-visible register image.
    always_comb begin
        reg_rdata = {ctrl.scrub_dis, addr_q, syn_q,
                     ctrl.berr_en, ctrl.nmi_en, mbe_flag, sbe_flag};
    end

    logic unused_addr_low;
    assign unused_addr_low = ^err_addr[DROP_W-1:0];
endmodule

// File: rtl/ecc_err_log_checker.sv
// Module: ecc_err_log_checker
// Port-level properties of the ECC error log, bound to the top module.
// Assumes inputs change only between clock edges.
module ecc_err_log_checker #(
    parameter int SYN_W = 8,
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sbe_pulse,
    input logic             mbe_pulse,
    input logic [SYN_W-1:0] err_syn,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             scrub_req,
    input logic             nmi_out,
    input logic             berr_out
);
    localparam int TOP = REG_W - 1;

    logic idle;
    logic clearing;
    assign idle     = (reg_rdata[1:0] == 2'b00);
    assign clearing = reg_wr && (reg_wdata[1:0] == 2'b11);

    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_rdata[1:0]));

    a_r2_sbe_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && sbe_pulse && !mbe_pulse) |=>
            (reg_rdata[1:0] == 2'b01) && (reg_rdata[SYN_W+3:4] == $past(err_syn)));

    a_r3_mbe_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && mbe_pulse) |=> (reg_rdata[1:0] == 2'b10));

    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !clearing) |=>
            $stable(reg_rdata[TOP-1:4]) && $stable(reg_rdata[1:0]));

    a_r6_clear_both: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && clearing) |=> (reg_rdata[1:0] == 2'b00));

    a_r12_fields_hold_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && clearing) |=> $stable(reg_rdata[TOP-1:4]));

    a_r8_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata[TOP] == $past(reg_wdata[TOP])) &&
                   (reg_rdata[3:2] == $past(reg_wdata[3:2])));

    a_r9_nmi_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_out |-> (reg_rdata[0] && reg_rdata[2]));

    a_r10_berr_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        berr_out |-> (reg_rdata[1] && reg_rdata[3]));

    a_r11_scrub_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (sbe_pulse && !mbe_pulse && !reg_rdata[TOP] && !(reg_wr && reg_wdata[TOP]))
            |=> scrub_req);

    a_r11_scrub_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!sbe_pulse || mbe_pulse) |=> !scrub_req);
endmodule

bind ecc_err_log ecc_err_log_checker #(.SYN_W(SYN_W), .REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sbe_pulse (sbe_pulse),
    .mbe_pulse (mbe_pulse),
    .err_syn   (err_syn),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .scrub_req (scrub_req),
    .nmi_out   (nmi_out),
    .berr_out  (berr_out)
);

// File: tb/tb_ecc_err_log.sv
`timescale 1ns/1ps
module tb_ecc_err_log;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sbe_pulse = 1'b0;
    logic        mbe_pulse = 1'b0;
    logic [31:0] err_addr = '0;
    logic [7:0]  err_syn = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        scrub_req;
    logic        nmi_out;
    logic        berr_out;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [31:0] ADR_A = 32'hDEAD_BEEF;
    localparam logic [31:0] ADR_B = 32'h1234_5678;

    always #10 clk = ~clk;

    ecc_err_log dut (
        .clk(clk), .rst_n(rst_n), .sbe_pulse(sbe_pulse), .mbe_pulse(mbe_pulse),
        .err_addr(err_addr), .err_syn(err_syn), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scrub_req(scrub_req),
        .nmi_out(nmi_out), .berr_out(berr_out)
    );

    function automatic logic [31:0] img(input logic dis, input logic [31:0] a,
                                        input logic [7:0] s, input logic be,
                                        input logic ne, input logic m, input logic sb);
        return {dis, a[31:13], s, be, ne, m, sb};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle of stimulus, applied on the falling edge; results are visible
    // at the following falling edge (after one rising edge).
    task automatic step(input logic w, input logic [31:0] wd, input logic s,
                        input logic m, input logic [31:0] a, input logic [7:0] y);
        @(negedge clk);
        reg_wr = w; reg_wdata = wd; sbe_pulse = s; mbe_pulse = m;
        err_addr = a; err_syn = y;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; sbe_pulse = 1'b0; mbe_pulse = 1'b0;
        err_addr = 32'h0BAD_0BAD; err_syn = 8'hEE;
    endtask

    task automatic t_reset();
        chk("R1 rdata", reg_rdata, 32'h0);
        chk("R1 outputs", {29'd0, scrub_req, nmi_out, berr_out}, 32'h0);
    endtask

    task automatic t_first_sbe();
        step(0, 0, 1, 0, ADR_A, 8'h5A);
        chk("R2 capture", reg_rdata, img(0, ADR_A, 8'h5A, 0, 0, 0, 1));
        chk("R11 scrub pulse", {31'd0, scrub_req}, 32'd1);
        chk("R9 nmi disabled", {31'd0, nmi_out}, 32'd0);
        @(negedge clk);
        chk("R11 scrub one cycle", {31'd0, scrub_req}, 32'd0);
    endtask

    task automatic t_frozen();
        step(0, 0, 0, 1, ADR_B, 8'hC3);
        chk("R5 mbe ignored", reg_rdata, img(0, ADR_A, 8'h5A, 0, 0, 0, 1));
        step(0, 0, 1, 0, ADR_B, 8'hC3);
        chk("R5 sbe ignored", reg_rdata, img(0, ADR_A, 8'h5A, 0, 0, 0, 1));
        chk("R11 scrub independent of flags", {31'd0, scrub_req}, 32'd1);
    endtask

    task automatic t_partial_clear();
        step(1, 32'h1, 0, 0, 0, 0);
        chk("R6 write 01", reg_rdata, img(0, ADR_A, 8'h5A, 0, 0, 0, 1));
        step(1, 32'h2, 0, 0, 0, 0);
        chk("R6 write 10", reg_rdata, img(0, ADR_A, 8'h5A, 0, 0, 0, 1));
        step(1, 32'h0, 0, 0, 0, 0);
        chk("R6 write 00", reg_rdata, img(0, ADR_A, 8'h5A, 0, 0, 0, 1));
        step(1, 32'h3, 0, 0, 0, 0);
        chk("R6 clear both", reg_rdata, img(0, ADR_A, 8'h5A, 0, 0, 0, 0));
    endtask

    task automatic t_readonly();
        step(1, 32'h7FFF_FFFC, 0, 0, 0, 0);
        chk("R12 fields not writable", reg_rdata, img(0, ADR_A, 8'h5A, 1, 1, 0, 0));
        step(1, 32'h8000_0000, 0, 0, 0, 0);
        chk("R8 control bits", reg_rdata, img(1, ADR_A, 8'h5A, 0, 0, 0, 0));
        step(1, 32'h0, 0, 0, 0, 0);
        chk("R8 control clear", reg_rdata, img(0, ADR_A, 8'h5A, 0, 0, 0, 0));
    endtask

    task automatic t_mbe_berr();
        step(1, 32'h8, 0, 0, 0, 0);
        step(0, 0, 0, 1, ADR_B, 8'hC3);
        chk("R3 R7 mbe capture", reg_rdata, img(0, ADR_B, 8'hC3, 1, 0, 1, 0));
        chk("R10 berr high", {29'd0, scrub_req, nmi_out, berr_out}, 32'd1);
        step(1, 32'hB, 0, 0, 0, 0);
        chk("R6 clear keeps enable", reg_rdata, img(0, ADR_B, 8'hC3, 1, 0, 0, 0));
        chk("R10 berr low", {31'd0, berr_out}, 32'd0);
    endtask

    task automatic t_both();
        step(1, 32'h0, 0, 0, 0, 0);
        step(0, 0, 1, 1, 32'hFFFF_E000, 8'h81);
        chk("R4 mbe wins", reg_rdata, img(0, 32'hFFFF_E000, 8'h81, 0, 0, 1, 0));
        chk("R11 no scrub with mbe", {31'd0, scrub_req}, 32'd0);
        step(1, 32'h3, 0, 0, 0, 0);
    endtask

    task automatic t_nmi();
        step(1, 32'h4, 0, 0, 0, 0);
        step(0, 0, 1, 0, 32'h0000_2000, 8'h01);
        chk("R9 R7 capture", reg_rdata, img(0, 32'h0000_2000, 8'h01, 0, 1, 0, 1));
        chk("R9 nmi high", {29'd0, scrub_req, nmi_out, berr_out}, 32'b110);
        step(1, 32'h7, 0, 0, 0, 0);
        chk("R9 nmi low after clear", {31'd0, nmi_out}, 32'd0);
        step(1, 32'h3, 0, 0, 0, 0);
    endtask

    task automatic t_scrub_off();
        step(1, 32'h8000_0000, 0, 0, 0, 0);
        step(0, 0, 1, 0, ADR_A, 8'h11);
        chk("R11 scrub disabled", {31'd0, scrub_req}, 32'd0);
        chk("R2 capture with scrub off", reg_rdata, img(1, ADR_A, 8'h11, 0, 0, 0, 1));
        step(1, 32'h8000_0003, 1, 0, ADR_B, 8'h22);
        chk("R5 pulse during clear ignored", reg_rdata, img(1, ADR_A, 8'h11, 0, 0, 0, 0));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_first_sbe();
        t_frozen();
        t_partial_clear();
        t_readonly();
        t_mbe_berr();
        t_both();
        t_nmi();
        t_scrub_off();
        finish_run();
    end
endmodule